// File: doc/BRIEF.md
# Minterm-Gated Adder ALU Slice

This block is a combinational ALU of parameterised width. It is built as a ripple chain of one-bit cells. Each cell is a full adder written as a two-level sum of products. An AND array decodes the eight minterms of (operand bit a, operand bit b, incoming carry). An OR gate collects the odd-parity rows into the sum bit, and a second OR gate collects the majority rows into the carry bit. One more AND row computes a AND b and feeds the sum OR gate. Each row has its own enable.

A two-bit operation selector turns those enables on and off. The same array then performs four operations: addition, exclusive-or, inclusive-or and and. There is no separate logic unit and no result multiplexer.

For addition the slice also reports the carry out of the top cell. It also reports a signed overflow flag, computed from the two top operand bits and the top sum bit. The external carry input takes part only in addition.

Top module: `mgalu_slice`

## Requirements
- R1: With op_i = 2'b00 (add), {cout_o, res_o} equals a_i + b_i + cin_i, taken as unsigned numbers of width W+1.
- R2: With op_i = 2'b01 (exclusive-or), res_o equals a_i ^ b_i bit by bit.
- R3: With op_i = 2'b10 (inclusive-or), res_o equals a_i | b_i bit by bit.
- R4: With op_i = 2'b11 (and), res_o equals a_i & b_i bit by bit.
- R5: For op_i values 01, 10 and 11, cin_i has no effect on res_o.
- R6: For op_i values 01, 10 and 11, cout_o and ovf_o are both 0.
- R7: With op_i = 2'b00, ovf_o is 1 exactly when the signed two's-complement sum a_i + b_i + cin_i lies outside the range of a W-bit signed number. That is the case when both top operand bits are equal and the top result bit differs from them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cin_i | input | 1 | Carry into bit 0, used by add only |
| op_i | input | 2 | Operation: 00 add, 01 xor, 10 or, 11 and |
| res_o | output | W | Result word |
| cout_o | output | 1 | Carry out of the top cell (add only) |
| ovf_o | output | 1 | Signed overflow (add only) |

## Verification
Carry out and signed overflow can be raised by the same addition. With W=4, the exhaustive sweep over every operand pair and both carry-in values produces this case. Adding two negative numbers whose sum passes the negative limit sets both flags, for example 4'h8 + 4'h8, which gives result 0 with cout_o = 1 and ovf_o = 1. The 32-bit runs reach the same case with 32'h80000000 + 32'h80000000. The bench judges each flag separately against its own reference: a wide unsigned sum for the carry out, and a signed range test for the overflow. A case where one flag is right and the other is wrong is therefore reported.

// File: rtl/mgalu_pkg.sv
package mgalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_XOR = 2'b01,
    OP_OR  = 2'b10,
    OP_AND = 2'b11
  } alu_op_e;

  // Row index = {a, b, c}, with c the least significant bit
  typedef struct packed {
    logic [7:0] row_en;
    logic       dup_en;   // extra a&b row that feeds the sum
    logic       cin_pass; // external carry passed to bit 0
  } row_ctrl_t;

  localparam logic [7:0] SUM_ROWS   = 8'b1001_0110; // rows 1,2,4,7
  localparam logic [7:0] CARRY_ROWS = 8'b1110_1000; // rows 3,5,6,7

  function automatic row_ctrl_t ctrl_for(alu_op_e op);
    row_ctrl_t c;
    case (op)
      OP_ADD:  c = '{row_en: 8'b1111_1111, dup_en: 1'b0, cin_pass: 1'b1};
      OP_XOR:  c = '{row_en: 8'b0001_0101, dup_en: 1'b0, cin_pass: 1'b0};
      OP_OR:   c = '{row_en: 8'b0001_0101, dup_en: 1'b1, cin_pass: 1'b0};
      default: c = '{row_en: 8'b0000_0001, dup_en: 1'b1, cin_pass: 1'b0};
    endcase
    return c;
  endfunction

  function automatic logic [7:0] decode_rows(logic a, logic b, logic c);
    return 8'b0000_0001 << {a, b, c};
  endfunction

  function automatic logic sign_flip(logic a, logic b, logic s);
    return (~a & ~b & s) | (a & b & ~s);
  endfunction

endpackage

// File: rtl/mgalu_row_ctrl.sv
module mgalu_row_ctrl
  import mgalu_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       cin_i,
  output row_ctrl_t  ctrl_o,
  output logic       cin_o,
  output logic       is_add_o
);
  alu_op_e op_w;

  always_comb begin
    op_w     = alu_op_e'(op_i);
    ctrl_o   = ctrl_for(op_w);
    cin_o    = cin_i & ctrl_o.cin_pass;
    is_add_o = (op_w == OP_ADD);
  end
endmodule

// File: rtl/mgalu_bit.sv
module mgalu_bit
  import mgalu_pkg::*;
(
  input  logic      a_i,
  input  logic      b_i,
  input  logic      c_i,
  input  row_ctrl_t ctrl_i,
  output logic      s_o,
  output logic      c_o
);
  logic [7:0] hit_w;
  logic       dup_w;

  always_comb begin
    hit_w = decode_rows(a_i, b_i, c_i) & ctrl_i.row_en;
    dup_w = a_i & b_i & ctrl_i.dup_en;
    s_o   = (|(hit_w & SUM_ROWS)) | dup_w;
    c_o   = |(hit_w & CARRY_ROWS);
  end
endmodule

// File: rtl/mgalu_flags.sv
module mgalu_flags
  import mgalu_pkg::*;
(
  input  logic is_add_i,
  input  logic a_top_i,
  input  logic b_top_i,
  input  logic s_top_i,
  input  logic c_top_i,
  output logic cout_o,
  output logic ovf_o
);
  always_comb begin
    cout_o = is_add_i & c_top_i;
    ovf_o  = is_add_i & sign_flip(a_top_i, b_top_i, s_top_i);
  end
endmodule

// File: rtl/mgalu_slice.sv
module mgalu_slice
  import mgalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic [1:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int TOP = W - 1;

  row_ctrl_t    ctrl_w;
  logic         is_add_w;
  logic [W:0]   chain_w;

  mgalu_row_ctrl u_ctrl (
    .op_i     (op_i),
    .cin_i    (cin_i),
    .ctrl_o   (ctrl_w),
    .cin_o    (chain_w[0]),
    .is_add_o (is_add_w)
  );

  for (genvar i = 0; i < W; i++) begin : g_cell
    mgalu_bit u_bit (
      .a_i    (a_i[i]),
      .b_i    (b_i[i]),
      .c_i    (chain_w[i]),
      .ctrl_i (ctrl_w),
      .s_o    (res_o[i]),
      .c_o    (chain_w[i+1])
    );
  end

  mgalu_flags u_flags (
    .is_add_i (is_add_w),
    .a_top_i  (a_i[TOP]),
    .b_top_i  (b_i[TOP]),
    .s_top_i  (res_o[TOP]),
    .c_top_i  (chain_w[W]),
    .cout_o   (cout_o),
    .ovf_o    (ovf_o)
  );
endmodule

// File: rtl/mgalu_slice_chk.sv
module mgalu_slice_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [1:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         cout_o,
  input logic         ovf_o,
  input logic [W:0]   chain_i
);
  localparam int TOP = W - 1;

  always_comb begin
    // R6
    logic_flags_chk: assert (op_i == 2'b00 || (!cout_o && !ovf_o))
      else $error("flags raised by a logic operation");
    // R2
    xor_chain_chk: assert (op_i != 2'b01 || chain_i == '0)
      else $error("carry chain active during xor");
    // R4
    and_subset_chk: assert (op_i != 2'b11 || ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0))
      else $error("and result has a bit outside the operands");
    // R3
    or_cover_chk: assert (op_i != 2'b10 || (res_o & (a_i | b_i)) == (a_i | b_i))
      else $error("or result misses an operand bit");
    // R7
    ovf_sign_chk: assert (!ovf_o || (a_i[TOP] == b_i[TOP] && res_o[TOP] != a_i[TOP]))
      else $error("overflow without a sign flip");
    // R5
    cin_mask_chk: assert (op_i == 2'b00 || !chain_i[0])
      else $error("external carry leaked into a logic operation");
  end
endmodule

bind mgalu_slice mgalu_slice_chk #(.W(W)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .op_i    (op_i),
  .res_o   (res_o),
  .cout_o  (cout_o),
  .ovf_o   (ovf_o),
  .chain_i (chain_w)
);

// File: tb/mgalu_slice_tb.sv
module mgalu_slice_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WS = 4;
  localparam int WL = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;

  logic [WS-1:0] sa, sb, sres;
  logic          scin, scout, sovf;
  logic [1:0]    sop;
  logic [WL-1:0] la, lb, lres;
  logic          lcin, lcout, lovf;
  logic [1:0]    lop;

  mgalu_slice #(.W(WS)) u_dut (
    .a_i(sa), .b_i(sb), .cin_i(scin), .op_i(sop),
    .res_o(sres), .cout_o(scout), .ovf_o(sovf)
  );

  mgalu_slice #(.W(WL)) u_dut32 (
    .a_i(la), .b_i(lb), .cin_i(lcin), .op_i(lop),
    .res_o(lres), .cout_o(lcout), .ovf_o(lovf)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  function automatic string op_req(logic [1:0] op);
    case (op)
      2'b00: return "R1 add";
      2'b01: return "R2 xor";
      2'b10: return "R3 or";
      default: return "R4 and";
    endcase
  endfunction

  // Expected values for the 4-bit instance, using integer arithmetic
  task automatic check_small();
    int ua, ub, us, ia, ib, isum;
    logic [WS-1:0] er;
    logic ec, ev;
    ua = int'(sa); ub = int'(sb);
    ia = (ua >= 8) ? ua - 16 : ua;
    ib = (ub >= 8) ? ub - 16 : ub;
    ec = 1'b0; ev = 1'b0;
    case (sop)
      2'b00: begin
        us   = ua + ub + int'(scin);
        er   = us[WS-1:0];
        ec   = (us >= 16);
        isum = ia + ib + int'(scin);
        ev   = (isum > 7) || (isum < -8);
      end
      2'b01: er = sa ^ sb;
      2'b10: er = sa | sb;
      default: er = sa & sb;
    endcase
    chk(op_req(sop), 64'(sres), 64'(er));
    if (sop == 2'b00) begin
      chk("R1 carry", 64'(scout), 64'(ec));
      chk("R7 overflow", 64'(sovf), 64'(ev));
    end else begin
      chk("R6 flags zero", 64'({scout, sovf}), 64'd0);
      if (scin) chk("R5 cin ignored", 64'(sres), 64'(er));
    end
  endtask

  // Expected values for the 32-bit instance, using wide signed arithmetic
  task automatic apply_large(input logic [1:0] op, input logic [WL-1:0] a,
                             input logic [WL-1:0] b, input logic c);
    logic [WL:0] wide;
    longint sum;
    logic [WL-1:0] er;
    @(posedge clk);
    lop = op; la = a; lb = b; lcin = c;
    @(negedge clk);
    case (op)
      2'b00: er = a + b + WL'(c);
      2'b01: er = a ^ b;
      2'b10: er = a | b;
      default: er = a & b;
    endcase
    chk(op_req(op), 64'(lres), 64'(er));
    if (op == 2'b00) begin
      wide = {1'b0, a} + {1'b0, b} + (WL+1)'(c);
      sum  = longint'($signed(a)) + longint'($signed(b)) + longint'(c);
      chk("R1 carry", 64'(lcout), 64'(wide[WL]));
      chk("R7 overflow", 64'(lovf),
          64'((sum > 64'sd2147483647) || (sum < -64'sd2147483648)));
    end else begin
      chk("R6 flags zero", 64'({lcout, lovf}), 64'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    sa = '0; sb = '0; scin = 1'b0; sop = 2'b00;
    la = '0; lb = '0; lcin = 1'b0; lop = 2'b00;
    @(negedge clk);
    chk("R1 idle result", 64'(sres), 64'd0);
    chk("R6 idle flags", 64'({scout, sovf}), 64'd0);

    // exhaustive sweep, 4-bit instance
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            @(posedge clk);
            sop = 2'(op); sa = 4'(a); sb = 4'(b); scin = 1'(c);
            @(negedge clk);
            check_small();
          end

    // directed corners, 32-bit instance
    apply_large(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0); // R1, R7: both flags
    apply_large(2'b00, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1); // R7 positive limit
    apply_large(2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
    apply_large(2'b00, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1); // R1 full ripple
    apply_large(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    apply_large(2'b00, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0);
    for (int op = 1; op < 4; op++) begin
      apply_large(2'(op), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1); // R5, R6
      apply_large(2'(op), 32'hA5A5_5A5A, 32'h0FF0_F00F, 1'b1);
    end

    // random vectors, 32-bit instance
    for (int op = 0; op < 4; op++)
      for (int n = 0; n < 2000; n++)
        apply_large(2'(op), $urandom, $urandom, 1'($urandom));

    finish_run();
  end
endmodule